// File: doc/BRIEF.md
# Burst Configuration Command Sequencer

This block sits on the write side of a burst-capable NOR flash command interface. It watches every write on the host bus and looks for a three-write sequence that loads the burst configuration register. The sequence is two unlock writes followed by a configuration command. The value that is loaded does not come from the data bus. It comes from the upper address bits of the command write.

The register selects whether reads run asynchronously or as synchronous bursts. It also sets the initial-access latency in clocks. Both settings are driven to a read-path controller. While an embedded program, erase or sector-lock operation runs, the busy input blocks any configuration load. The sequencer state is brought out on a debug port so that each step of the sequence can be observed.

Top module: `burst_cfg_seq`

## Requirements
- R1: On a clock edge with `rst` high, `seq_state` becomes 0 and `cfg_code` becomes 8'hFF, so `sync_mode` is 0 (asynchronous) and `wait_clocks` is 9.
- R2: The sequence is three strobed writes, where only `data[7:0]` and `addr[11:0]` are compared. The writes are: 8'hAA at 12'h555, then 8'h55 at 12'h2AA, then 8'hC0 at 12'h555 with `busy` low. After this sequence, `cfg_code` takes `addr[19:12]` of the third write on the clock edge that samples it.
- R3: `sync_mode` is 1 exactly when `cfg_code[7]` is 0. Bit 7 is 1 for asynchronous and 0 for synchronous burst.
- R4: `wait_code` equals `cfg_code[2:0]`, and `wait_clocks` equals that code plus 2. The range is 2 to 9.
- R5: If `busy` is high during the third write, `cfg_code` keeps its value and `seq_state` returns to 0.
- R6: If the third write has the wrong data or the wrong `addr[11:0]`, `cfg_code` keeps its value and `seq_state` returns to 0.
- R7: If a write does not match the expected unlock cycle, `seq_state` returns to 0 and `cfg_code` does not change.
- R8: A write with `data[7:0]` = 8'hF0 at any address returns `seq_state` to 0 from any state and never loads `cfg_code`.
- R9: `seq_state` is 0 when idle, 1 after the first unlock and 2 after the second unlock. It never takes the value 3.
- R10: On cycles with `wr_en` low, `seq_state` and `cfg_code` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| addr | input | 20 | Word address of the write |
| data | input | 16 | Write data |
| busy | input | 1 | An embedded program, erase or lock operation is running |
| cfg_code | output | 8 | Latched configuration code |
| sync_mode | output | 1 | 1 = synchronous burst reads |
| wait_code | output | 3 | Wait-state code |
| wait_clocks | output | 4 | Initial-access latency in clocks |
| seq_state | output | 2 | Debug: sequencer step |

## Verification
A wrong sequencer step can show up in two ways. It can show on `seq_state` one cycle after the write that caused it. It can also show later, when a valid command is missed or a spurious load happens. A corrupt register shows at once on `cfg_code`, `sync_mode` and `wait_clocks` in the cycle after the edge. Random writes are biased toward the command patterns, with busy, abort and mismatch writes mixed in. A bench model is compared against these ports after every write.

// File: rtl/burst_cfg_pkg.sv
package burst_cfg_pkg;
    localparam int ADDR_W     = 20;
    localparam int DATA_W     = 16;
    localparam int CODE_LSB   = 12;
    localparam int CODE_W     = ADDR_W - CODE_LSB;
    localparam int WS_W       = 3;
    localparam int WS_OFFSET  = 2;
    localparam int CLK_W      = WS_W + 1;
    localparam int MODE_BIT   = CODE_W - 1;

    localparam logic [11:0] UNLOCK_A1 = 12'h555;
    localparam logic [11:0] UNLOCK_A2 = 12'h2AA;
    localparam logic [7:0]  UNLOCK_D1 = 8'hAA;
    localparam logic [7:0]  UNLOCK_D2 = 8'h55;
    localparam logic [7:0]  LOAD_CMD  = 8'hC0;
    localparam logic [7:0]  ABORT_CMD = 8'hF0;
    localparam logic [CODE_W-1:0] CODE_DEFAULT = '1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_KEY1 = 2'd1,
        ST_KEY2 = 2'd2
    } seq_t;

    typedef struct packed {
        logic abort;
        logic key1;
        logic key2;
        logic load;
    } hit_t;

    function automatic logic [CLK_W-1:0] ws_to_clocks(input logic [WS_W-1:0] c);
        return CLK_W'(c) + CLK_W'(WS_OFFSET);
    endfunction
endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
    import burst_cfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output hit_t              hit
);
    logic [11:0] lo_addr;
    logic [7:0]  lo_data;

    always_comb begin
        lo_addr   = addr[11:0];
        lo_data   = data[7:0];
        hit.abort = (lo_data == ABORT_CMD);
        hit.key1  = (lo_addr == UNLOCK_A1) && (lo_data == UNLOCK_D1);
        hit.key2  = (lo_addr == UNLOCK_A2) && (lo_data == UNLOCK_D2);
        hit.load  = (lo_addr == UNLOCK_A1) && (lo_data == LOAD_CMD);
    end
endmodule

// File: rtl/burst_cfg_fsm.sv
module burst_cfg_fsm
    import burst_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic busy,
    input  hit_t hit,
    output seq_t state,
    output logic load_fire
);
    seq_t nxt;

    always_comb begin
        nxt       = state;
        load_fire = 1'b0;
        if (wr_en) begin
            nxt = ST_IDLE;
            if (!hit.abort) begin
                unique case (state)
                    ST_IDLE: if (hit.key1) nxt = ST_KEY1;
                    ST_KEY1: if (hit.key2) nxt = ST_KEY2;
                    ST_KEY2: load_fire = hit.load && !busy;
                    default: nxt = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
    import burst_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_q
);
    always_ff @(posedge clk) begin
        if (rst)       code_q <= CODE_DEFAULT;
        else if (load) code_q <= code_in;
    end
endmodule

// File: rtl/burst_cfg_seq.sv
module burst_cfg_seq
    import burst_cfg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        data,
    input  logic                     busy,
    output logic [CODE_W-1:0]        cfg_code,
    output logic                     sync_mode,
    output logic [WS_W-1:0]          wait_code,
    output logic [CLK_W-1:0]         wait_clocks,
    output logic [1:0]               seq_state
);
    hit_t hit;
    seq_t state;
    logic load_fire;

    burst_cfg_decode u_dec (.addr(addr), .data(data), .hit(hit));

    burst_cfg_fsm u_fsm (
        .clk(clk), .rst(rst), .wr_en(wr_en), .busy(busy),
        .hit(hit), .state(state), .load_fire(load_fire)
    );

    burst_cfg_reg u_reg (
        .clk(clk), .rst(rst), .load(load_fire),
        .code_in(addr[ADDR_W-1:CODE_LSB]), .code_q(cfg_code)
    );

    always_comb begin
        sync_mode   = ~cfg_code[MODE_BIT];
        wait_code   = cfg_code[WS_W-1:0];
        wait_clocks = ws_to_clocks(cfg_code[WS_W-1:0]);
        seq_state   = state;
    end
endmodule

// File: rtl/burst_cfg_seq_chk.sv
module burst_cfg_seq_chk
    import burst_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] data,
    input logic              busy,
    input logic [CODE_W-1:0] cfg_code,
    input logic [CLK_W-1:0]  wait_clocks,
    input logic [1:0]        seq_state
);
    assert_state_legal_R9: assert property (@(posedge clk) disable iff (rst)
        seq_state != 2'd3);

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(cfg_code) && $stable(seq_state)));

    assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> $stable(cfg_code));

    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && data[7:0] == ABORT_CMD) |=> (seq_state == 2'd0 && $stable(cfg_code)));

    assert_mismatch_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && seq_state == 2'd0 && !(addr[11:0] == UNLOCK_A1 && data[7:0] == UNLOCK_D1))
        |=> (seq_state == 2'd0 && $stable(cfg_code)));

    assert_load_value_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && seq_state == 2'd2 && addr[11:0] == UNLOCK_A1 && data[7:0] == LOAD_CMD)
        |=> (cfg_code == $past(addr[ADDR_W-1:CODE_LSB])));

    assert_wait_range_R4: assert property (@(posedge clk) disable iff (rst)
        (wait_clocks >= CLK_W'(WS_OFFSET)) && (wait_clocks <= CLK_W'(WS_OFFSET + 7)));
endmodule

bind burst_cfg_seq burst_cfg_seq_chk i_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .data(data), .busy(busy),
    .cfg_code(cfg_code), .wait_clocks(wait_clocks), .seq_state(seq_state)
);

// File: tb/test_burst_cfg_seq.sv
module test_burst_cfg_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [19:0] addr = '0;
    logic [15:0] data = '0;
    logic        busy = 1'b0;
    logic [7:0]  cfg_code;
    logic        sync_mode;
    logic [2:0]  wait_code;
    logic [3:0]  wait_clocks;
    logic [1:0]  seq_state;

    int checks = 0;
    int failures = 0;
    logic [1:0] m_state = 2'd0;
    logic [7:0] m_cfg = 8'hFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_cfg_seq i_burst_cfg_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .data(data), .busy(busy),
        .cfg_code(cfg_code), .sync_mode(sync_mode), .wait_code(wait_code),
        .wait_clocks(wait_clocks), .seq_state(seq_state)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected behaviour taken from the requirements.
    task automatic model_write(input logic [19:0] a, input logic [15:0] d, input logic b);
        if (d[7:0] == 8'hF0) m_state = 2'd0;
        else case (m_state)
            2'd0: m_state = (a[11:0] == 12'h555 && d[7:0] == 8'hAA) ? 2'd1 : 2'd0;
            2'd1: m_state = (a[11:0] == 12'h2AA && d[7:0] == 8'h55) ? 2'd2 : 2'd0;
            default: begin
                if (a[11:0] == 12'h555 && d[7:0] == 8'hC0 && !b) m_cfg = a[19:12];
                m_state = 2'd0;
            end
        endcase
    endtask

    task automatic check_outputs(input string req);
        chk({req, " state"}, seq_state, m_state);
        chk({req, " code"}, cfg_code, m_cfg);
        chk("R3 sync_mode", sync_mode, !m_cfg[7]);
        chk("R4 wait_clocks", wait_clocks, m_cfg[2:0] + 2);
        chk("R4 wait_code", wait_code, m_cfg[2:0]);
    endtask

    task automatic wr(input logic [19:0] a, input logic [15:0] d, input logic b, input string req);
        @(negedge clk);
        wr_en = 1'b1; addr = a; data = d; busy = b;
        @(negedge clk);
        wr_en = 1'b0; busy = 1'b0;
        model_write(a, d, b);
        check_outputs(req);
    endtask

    task automatic full_seq(input logic [7:0] code, input logic b, input string req);
        wr(20'h00555, 16'h00AA, 1'b0, req);
        wr(20'h002AA, 16'h0055, 1'b0, req);
        wr({code, 12'h555}, 16'h00C0, b, req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_outputs("R1 reset");
        chk("R1 sync_mode", sync_mode, 0);
        chk("R1 wait_clocks", wait_clocks, 9);

        full_seq(8'h03, 1'b0, "R2 load");
        chk("R3 sync after load", sync_mode, 1);
        chk("R4 five clocks", wait_clocks, 5);
        full_seq(8'h80, 1'b0, "R2 async code");
        full_seq(8'h05, 1'b1, "R5 busy load");
        chk("R5 code held", cfg_code, 8'h80);
        wr(20'h00555, 16'h00AA, 1'b0, "R6");
        wr(20'h002AA, 16'h0055, 1'b0, "R6");
        wr(20'h12556, 16'h00C0, 1'b0, "R6 bad addr");
        wr(20'h00555, 16'h00AA, 1'b0, "R6");
        wr(20'h002AA, 16'h0055, 1'b0, "R6");
        wr(20'h12555, 16'h00C1, 1'b0, "R6 bad data");
        wr(20'h00555, 16'h00AA, 1'b0, "R7");
        wr(20'h002AB, 16'h0055, 1'b0, "R7 bad key2");
        wr(20'h00555, 16'h00AB, 1'b0, "R7 bad key1");
        wr(20'h00555, 16'h00AA, 1'b0, "R8");
        wr(20'h00555, 16'h00F0, 1'b0, "R8 abort key1");
        wr(20'h00555, 16'h00AA, 1'b0, "R8");
        wr(20'h002AA, 16'h0055, 1'b0, "R8");
        wr(20'h7F555, 16'h00F0, 1'b0, "R8 abort key2");
        wr(20'h00555, 16'h00AA, 1'b0, "R10");
        repeat (4) @(negedge clk);
        check_outputs("R10 idle cycles");
        chk("R9 step one", seq_state, 1);
        wr(20'h002AA, 16'h0055, 1'b0, "R9");
        chk("R9 step two", seq_state, 2);
        wr(20'hFF555, 16'hABC0, 1'b0, "R2 upper data ignored");
        chk("R2 max code", cfg_code, 8'hFF);
        full_seq(8'h00, 1'b0, "R4 min");
        chk("R4 two clocks", wait_clocks, 2);

        for (int i = 0; i < 600; i++) begin
            logic [19:0] a;
            logic [15:0] d;
            logic b;
            int sel;
            sel = $urandom_range(0, 5);
            a = 20'($urandom);
            d = 16'($urandom);
            b = ($urandom_range(0, 4) == 0);
            case (sel)
                0: begin a[11:0] = 12'h555; d[7:0] = 8'hAA; end
                1: begin a[11:0] = 12'h2AA; d[7:0] = 8'h55; end
                2: begin a[11:0] = 12'h555; d[7:0] = 8'hC0; end
                3: d[7:0] = 8'hF0;
                default: ;
            endcase
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk);
                check_outputs("R10 random gap");
            end
            wr(a, d, b, "R2 random");
        end

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_state = 2'd0; m_cfg = 8'hFF;
        check_outputs("R1 second reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule